// File: doc/BRIEF.md
# AES Byte Substitution Unit (Forward and Inverse)

This block performs the AES byte substitution in either direction on one byte. A single mode bit picks the direction. With the bit low it applies the encryption S-box. With the bit high it applies the decryption S-box. The output depends only on the two inputs: there is no clock, no reset and no stored state. Several copies can therefore sit side by side in a datapath that completes a whole cipher round within one clock period.

The mapping is computed from field arithmetic instead of being read from a 256-entry table. An input linear layer applies the inverse affine map in decrypt mode and passes the byte through unchanged in encrypt mode. Both directions then share one multiplicative-inversion core over GF(2^8), using the reduction polynomial x^8+x^4+x^3+x+1. The core raises its operand to the power 254 with a chain of XOR-only squarers and field multipliers, and it maps zero to zero. An output linear layer applies the forward affine map in encrypt mode and passes the core result through in decrypt mode.

The unit has no mask, share or random input. No value other than the data byte and the mode bit affects the result.

Top module: `aes_sub_unit`

## Requirements
- R1: With `dec_mode` = 0, `sub_out` equals A(x^254) for every `sub_in` x. A(b) = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63, and the field is GF(2^8) with reduction polynomial 0x11B.
- R2: With `dec_mode` = 1, `sub_out` equals the unique y for which the R1 mapping of y gives `sub_in`, for all 256 inputs.
- R3: In encrypt mode the fixed sample points hold: 0x00→0x63, 0x01→0x7C, 0x02→0x77, 0x03→0x7B. The zero input is treated as its own inverse.
- R4: Round trip: feeding the encrypt-mode output back in with `dec_mode` = 1 returns the original byte for every byte. Examples are 0x63→0x00 and 0x7C→0x01.
- R5: In both modes no byte maps to itself and no byte maps to its bitwise complement.
- R6: In each mode the 256 outputs are pairwise distinct, so each mode is a permutation of the byte values.
- R7: The output is a pure function of `sub_in` and `dec_mode`. Returning to an earlier input pair reproduces the earlier output, whatever inputs were applied in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sub_in | input | 8 | Byte to be substituted |
| dec_mode | input | 1 | 0 selects the encrypt S-box, 1 selects the decrypt S-box |
| sub_out | output | 8 | Substituted byte |

## Verification
The bench builds the unit with its default byte width of 8, which is the only width the AES field allows. At that width the whole input space in both modes is just 512 points, so every input pair is applied and compared. The expected tables are built in the bench by a shift-and-reduce multiplier, a brute-force inverse search and the rotate form of the affine map. This puts exact equality, round-trip identity, the permutation property and the absence of fixed and complement-fixed points all within reach of exhaustive checking.

// File: rtl/aes_sub_pkg.sv
package aes_sub_pkg;

    // Byte width of the field elements
    localparam int unsigned BYTE_W = 8;
    // Width of an unreduced carry-less product
    localparam int unsigned PROD_W = 2 * BYTE_W - 1;
    // x^8 + x^4 + x^3 + x + 1
    localparam logic [BYTE_W:0] FIELD_POLY = 9'h11B;
    // Constant added after the forward affine rotation sum
    localparam logic [BYTE_W-1:0] FWD_ADD = 8'h63;
    // Constant added after the inverse affine rotation sum
    localparam logic [BYTE_W-1:0] INV_ADD = 8'h05;
    // Number of squarings to form x^(2^k), k = 1..BYTE_W-1
    localparam int unsigned SQ_STEPS = BYTE_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PROD_W-1:0] prod_t;

    typedef enum logic {
        MODE_ENC = 1'b0,
        MODE_DEC = 1'b1
    } sub_mode_e;

    // Fold a carry-less product back into the field
    function automatic byte_t gf_reduce(input prod_t p);
        prod_t r;
        r = p;
        for (int i = PROD_W - 1; i >= BYTE_W; i--) begin
            if (r[i]) begin
                r = r ^ (prod_t'(FIELD_POLY) << (i - BYTE_W));
            end
        end
        return r[BYTE_W-1:0];
    endfunction

    // General field product: AND array plus XOR tree plus reduction
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        prod_t p;
        p = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) begin
                p = p ^ (prod_t'(a) << i);
            end
        end
        return gf_reduce(p);
    endfunction

    // Squaring is linear over GF(2): spread bits to even positions, reduce
    function automatic byte_t gf_square(input byte_t a);
        prod_t p;
        p = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            p[2*i] = a[i];
        end
        return gf_reduce(p);
    endfunction

endpackage

// File: rtl/aes_sub_in_layer.sv
// Input linear layer: inverse affine map in decrypt mode, identity otherwise.
module aes_sub_in_layer
    import aes_sub_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic [W-1:0] u_in,
    input  logic         dec_sel,
    output logic [W-1:0] v_d
);

    logic [W-1:0] inv_aff;

    // b_i = u_(i+2) ^ u_(i+5) ^ u_(i+7) ^ c_i, indices mod W
    for (genvar i = 0; i < W; i++) begin : g_inv_bit
        localparam int unsigned TAP_A = (i + 2) % W;
        localparam int unsigned TAP_B = (i + 5) % W;
        localparam int unsigned TAP_C = (i + 7) % W;
        assign inv_aff[i] = u_in[TAP_A] ^ u_in[TAP_B] ^ u_in[TAP_C] ^ INV_ADD[i];
    end

    always_comb begin
        v_d = dec_sel ? inv_aff : u_in;
    end

endmodule

// File: rtl/aes_sub_gf_inv.sv
// Shared multiplicative inversion: a^254 = a^2 * a^4 * ... * a^128.
// Zero maps to zero because every factor is zero.
module aes_sub_gf_inv
    import aes_sub_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic [W-1:0] a_in,
    output logic [W-1:0] inv_d
);

    localparam int unsigned STEPS = W - 1;

    // pw[k] = a^(2^k)
    logic [W-1:0] pw  [STEPS+1];
    // acc[k] = a^(2 + 4 + ... + 2^k)
    logic [W-1:0] acc [STEPS+1];

    assign pw[0]  = a_in;
    assign acc[0] = '0;

    for (genvar k = 1; k <= STEPS; k++) begin : g_square
        assign pw[k] = gf_square(pw[k-1]);
    end

    assign acc[1] = pw[1];

    for (genvar k = 2; k <= STEPS; k++) begin : g_mult
        assign acc[k] = gf_mul(acc[k-1], pw[k]);
    end

    assign inv_d = acc[STEPS];

endmodule

// File: rtl/aes_sub_out_layer.sv
// Output linear layer: forward affine map in encrypt mode, identity otherwise.
module aes_sub_out_layer
    import aes_sub_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic [W-1:0] g_in,
    input  logic         dec_sel,
    output logic [W-1:0] s_d
);

    logic [W-1:0] fwd_aff;

    // s_i = g_i ^ g_(i+4) ^ g_(i+5) ^ g_(i+6) ^ g_(i+7) ^ c_i, indices mod W
    for (genvar i = 0; i < W; i++) begin : g_fwd_bit
        localparam int unsigned TAP_4 = (i + 4) % W;
        localparam int unsigned TAP_5 = (i + 5) % W;
        localparam int unsigned TAP_6 = (i + 6) % W;
        localparam int unsigned TAP_7 = (i + 7) % W;
        assign fwd_aff[i] = g_in[i] ^ g_in[TAP_4] ^ g_in[TAP_5]
                          ^ g_in[TAP_6] ^ g_in[TAP_7] ^ FWD_ADD[i];
    end

    always_comb begin
        s_d = dec_sel ? g_in : fwd_aff;
    end

endmodule

// File: rtl/aes_sub_unit.sv
module aes_sub_unit
    import aes_sub_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic [W-1:0] sub_in,
    input  logic         dec_mode,
    output logic [W-1:0] sub_out
);

    logic [W-1:0] lin_d;
    logic [W-1:0] inv_d;
    logic         dec_sel;

    assign dec_sel = (sub_mode_e'(dec_mode) == MODE_DEC);

    aes_sub_in_layer #(.W(W)) in_layer_i (
        .u_in    (sub_in),
        .dec_sel (dec_sel),
        .v_d     (lin_d)
    );

    aes_sub_gf_inv #(.W(W)) inv_core_i (
        .a_in  (lin_d),
        .inv_d (inv_d)
    );

    aes_sub_out_layer #(.W(W)) out_layer_i (
        .g_in    (inv_d),
        .dec_sel (dec_sel),
        .s_d     (sub_out)
    );

endmodule

// File: rtl/aes_sub_unit_chk.sv
module aes_sub_unit_chk #(
    parameter int unsigned W = 8
) (
    input logic [W-1:0] sub_in,
    input logic         dec_mode,
    input logic [W-1:0] sub_out
);

    always_comb begin
        // R3: zero input in encrypt mode
        if (!dec_mode && sub_in == 8'h00) begin
            assert_enc_zero_R3: assert (sub_out == 8'h63);
        end
        // R3: sample point 0x01 in encrypt mode
        if (!dec_mode && sub_in == 8'h01) begin
            assert_enc_one_R3: assert (sub_out == 8'h7C);
        end
        // R4: decrypt side of the round trip for the zero byte
        if (dec_mode && sub_in == 8'h63) begin
            assert_dec_zero_R4: assert (sub_out == 8'h00);
        end
        // R4: decrypt side of the round trip for the byte 0x01
        if (dec_mode && sub_in == 8'h7C) begin
            assert_dec_one_R4: assert (sub_out == 8'h01);
        end
        // R5: no fixed points in either mode
        assert_no_fixed_point_R5: assert (sub_out != sub_in);
        // R5: no complement-fixed points in either mode
        assert_no_compl_point_R5: assert (sub_out != ~sub_in);
    end

endmodule

bind aes_sub_unit aes_sub_unit_chk #(.W(W)) chk_i (
    .sub_in   (sub_in),
    .dec_mode (dec_mode),
    .sub_out  (sub_out)
);

// File: tb/aes_sub_unit_tb_top.sv
module aes_sub_unit_tb_top;

    logic       clk = 1'b0;
    logic [7:0] sub_in = 8'h00;
    logic       dec_mode = 1'b0;
    logic [7:0] sub_out;

    int unsigned n_cmp  = 0;
    int unsigned n_bad  = 0;
    bit          done   = 1'b0;

    logic [7:0] fwd_tab [256];
    logic [7:0] inv_tab [256];

    // 50 MHz
    always #10 clk = ~clk;

    aes_sub_unit dut_i (
        .sub_in   (sub_in),
        .dec_mode (dec_mode),
        .sub_out  (sub_out)
    );

    // Reference multiplier: repeated doubling with conditional accumulate
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] x;
        logic [7:0] r;
        x = a;
        r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
        end
        return r;
    endfunction

    // Reference inverse by exhaustive search
    function automatic logic [7:0] ref_inv(input logic [7:0] a);
        logic [7:0] res;
        res = 8'h00;
        if (a != 8'h00) begin
            for (int y = 1; y < 256; y++) begin
                if (ref_mul(a, 8'(y)) == 8'h01) res = 8'(y);
            end
        end
        return res;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] ref_affine(input logic [7:0] b);
        return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] b, input logic m);
        @(negedge clk);
        sub_in   = b;
        dec_mode = m;
        #2;
    endtask

    initial begin
        logic [7:0] y;
        bit         seen [256];

        for (int x = 0; x < 256; x++) begin
            fwd_tab[x] = ref_affine(ref_inv(8'(x)));
        end
        for (int x = 0; x < 256; x++) begin
            inv_tab[fwd_tab[x]] = 8'(x);
        end

        // Value at start with the idle inputs (encrypt, zero byte)
        @(negedge clk);
        #2;
        check("R3 idle zero", sub_out, 8'h63);

        // R3: fixed sample points
        apply(8'h00, 1'b0); check("R3 00", sub_out, 8'h63);
        apply(8'h01, 1'b0); check("R3 01", sub_out, 8'h7C);
        apply(8'h02, 1'b0); check("R3 02", sub_out, 8'h77);
        apply(8'h03, 1'b0); check("R3 03", sub_out, 8'h7B);

        // R4: named inverse points
        apply(8'h63, 1'b1); check("R4 63", sub_out, 8'h00);
        apply(8'h7C, 1'b1); check("R4 7C", sub_out, 8'h01);

        // R1, R5, R6: full encrypt sweep
        for (int x = 0; x < 256; x++) seen[x] = 1'b0;
        for (int x = 0; x < 256; x++) begin
            apply(8'(x), 1'b0);
            check("R1 encrypt", sub_out, fwd_tab[x]);
            n_cmp++;
            if (sub_out == 8'(x) || sub_out == ~8'(x)) begin
                n_bad++;
                $display("FAIL R5 encrypt in %02h: actual %02h expected neither %02h nor %02h",
                         x, sub_out, 8'(x), ~8'(x));
            end
            n_cmp++;
            if (seen[sub_out]) begin
                n_bad++;
                $display("FAIL R6 encrypt repeat in %02h: actual %02h expected unseen value",
                         x, sub_out);
            end
            seen[sub_out] = 1'b1;
        end

        // R2, R5, R6: full decrypt sweep
        for (int x = 0; x < 256; x++) seen[x] = 1'b0;
        for (int x = 0; x < 256; x++) begin
            apply(8'(x), 1'b1);
            check("R2 decrypt", sub_out, inv_tab[x]);
            n_cmp++;
            if (sub_out == 8'(x) || sub_out == ~8'(x)) begin
                n_bad++;
                $display("FAIL R5 decrypt in %02h: actual %02h expected neither %02h nor %02h",
                         x, sub_out, 8'(x), ~8'(x));
            end
            n_cmp++;
            if (seen[sub_out]) begin
                n_bad++;
                $display("FAIL R6 decrypt repeat in %02h: actual %02h expected unseen value",
                         x, sub_out);
            end
            seen[sub_out] = 1'b1;
        end

        // R4: round trip through the unit itself
        for (int x = 0; x < 256; x++) begin
            apply(8'(x), 1'b0);
            y = sub_out;
            apply(y, 1'b1);
            check("R4 round trip", sub_out, 8'(x));
        end

        // R7: revisiting an input pair after unrelated traffic
        apply(8'h53, 1'b0); check("R7 first visit", sub_out, fwd_tab[8'h53]);
        apply(8'hCA, 1'b1); check("R7 intervening", sub_out, inv_tab[8'hCA]);
        apply(8'hFF, 1'b0); check("R7 intervening", sub_out, fwd_tab[8'hFF]);
        apply(8'h53, 1'b0); check("R7 revisit", sub_out, fwd_tab[8'h53]);
        apply(8'h53, 1'b1); check("R7 mode flip", sub_out, inv_tab[8'h53]);
        apply(8'h53, 1'b0); check("R7 mode back", sub_out, fwd_tab[8'h53]);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule